// File: doc/BRIEF.md
# Complex Rotate Multiply-Accumulate Operand Steering

This block sits in front of a bank of fused multiply-add units in a vector floating-point pipeline. It takes one 32-bit complex multiply-accumulate instruction word, decodes the element size, the vector width and a two-bit rotation code, and flags any encoding that is not legal. Three 128-bit vectors come with the word: a first source, a second source and an accumulator. The block pairs their elements into complex numbers. The even element of each pair is the real part and the odd element is the imaginary part.

For every element lane the block produces an addend, a multiplicand and a multiplier. Each lane's fused multiply-add unit then computes `addend + multiplicand * multiplier` with no intermediate rounding. The rotation code selects which real or imaginary parts are routed to each lane and which of them are negated. This lets the accumulation use the product rotated by 0, 90, 180 or 270 degrees, so that two issues with suitable codes form a full complex multiply. Negation only flips the sign bit, which makes it exact for every value, NaNs included.

The results are held in one register stage, together with a lane-valid mask and the illegal-encoding flag. A valid bit follows the data through that stage.

Top module: `cmla_steer`

## Requirements
- R1: The word is legal only when bit 31 = 0, bits 29:24 = 101110, bit 21 = 0, bits 15:13 = 110 and bit 10 = 1. Any other value of these bits raises `out_undef`.
- R2: `out_undef` is also raised when the size field (bits 23:22) is 00, when Q (bit 30) is 0 and size is 11, or when size is 01 and `half_en` is 0. Otherwise it is 0. Element width is 8 << size bits, and vector width is 128 bits when Q = 1 and 64 bits when Q = 0.
- R3: When `out_undef` is 1, `out_mask`, `out_addend`, `out_mcand` and `out_mplier` are all zero.
- R4: For rotation (bits 12:11) 00, each pair has real lane (mcand, mplier) = (A.re, B.re) and imaginary lane (mcand, mplier) = (A.re, B.im).
- R5: For rotation 01, the real lane is (A.im, -B.im) and the imaginary lane is (A.im, B.re).
- R6: For rotation 10, the real lane is (A.re, -B.re) and the imaginary lane is (A.re, -B.im).
- R7: For rotation 11, the real lane is (A.im, B.im) and the imaginary lane is (A.im, -B.re).
- R8: Negating an element inverts only its top bit and leaves every other bit unchanged. NaN payloads are included.
- R9: Each lane's addend is the matching accumulator element, unchanged.
- R10: When Q = 0, bits 127:64 of `out_addend`, `out_mcand` and `out_mplier` are zero.
- R11: Bit i of `out_mask` is 1 exactly when i is below the element count (vector width / element width). This gives 8 or 4 lanes for 16-bit elements, 4 or 2 for 32-bit and 2 for 64-bit.
- R12: Outputs are registered. `out_valid` equals `in_valid` one clock later, and a word is captured only when `in_valid` is 1, so all other outputs hold otherwise. A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word and operands are present this cycle |
| insn | input | 32 | Instruction word |
| half_en | input | 1 | Half-precision elements permitted |
| src_a | input | 128 | First source vector (A) |
| src_b | input | 128 | Second source vector (B) |
| acc | input | 128 | Accumulator vector |
| out_valid | output | 1 | Registered outputs are new this cycle |
| out_undef | output | 1 | Captured word was illegal |
| out_mask | output | 8 | Lane-valid mask, one bit per 16-bit slot index |
| out_addend | output | 128 | Per-lane addend |
| out_mcand | output | 128 | Per-lane multiplicand |
| out_mplier | output | 128 | Per-lane multiplier |

## Verification
On every cycle the assertions check the following:
- the one-cycle valid timing and the hold of the outputs on idle cycles;
- that an illegal word yields all-zero outputs;
- that the mask is a contiguous run from lane 0 of at least two lanes;
- that the addend passes through for 128-bit words;
- that the upper half is zero for 64-bit words;
- that a zero size field is rejected.

Only the bench scenarios show the per-rotation routing and the sign flips for each element width, where the NaN payload must survive negation. The same holds for the exact lane count for each size and width, and for each individual cause of an illegal encoding.

// File: rtl/cmla_steer.sv
module cmla_steer #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic          half_en,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] acc,
  output logic          out_valid,
  output logic          out_undef,
  output logic [VW/16-1:0] out_mask,
  output logic [VW-1:0] out_addend,
  output logic [VW-1:0] out_mcand,
  output logic [VW-1:0] out_mplier
);
  localparam int HW = VW / 2;
  localparam int MW = VW / 16;

  logic       q;
  logic [1:0] sz;
  logic [1:0] rot;
  logic       fixed_ok;
  logic       undef;
  logic       unused_fields;

  assign q   = insn[30];
  assign sz  = insn[23:22];
  assign rot = insn[12:11];
  assign unused_fields = ^{insn[20:16], insn[9:0]};

  assign fixed_ok = !insn[31] && insn[29:24] == 6'b101110 && !insn[21] &&
                    insn[15:13] == 3'b110 && insn[10];
  assign undef = !fixed_ok || sz == 2'b00 || (!q && sz == 2'b11) ||
                 (sz == 2'b01 && !half_en);

  for (genvar s = 0; s < 3; s++) begin : g_sz
    localparam int ES = 16 << s;
    localparam int NP = VW / (2 * ES);
    wire [VW-1:0] mc;
    wire [VW-1:0] mp;
    for (genvar p = 0; p < NP; p++) begin : g_pair
      logic [ES-1:0] ar, ai, br, bi, nbr, nbi;
      logic [ES-1:0] mre, mim, pre, pim;
      assign ar  = src_a[(2*p)*ES +: ES];
      assign ai  = src_a[(2*p+1)*ES +: ES];
      assign br  = src_b[(2*p)*ES +: ES];
      assign bi  = src_b[(2*p+1)*ES +: ES];
      assign nbr = {~br[ES-1], br[ES-2:0]};
      assign nbi = {~bi[ES-1], bi[ES-2:0]};
      always_comb begin
        case (rot)
          2'b00:   begin mre = ar; pre = br;  mim = ar; pim = bi;  end
          2'b01:   begin mre = ai; pre = nbi; mim = ai; pim = br;  end
          2'b10:   begin mre = ar; pre = nbr; mim = ar; pim = nbi; end
          default: begin mre = ai; pre = bi;  mim = ai; pim = nbr; end
        endcase
      end
      assign mc[(2*p)*ES +: ES]   = mre;
      assign mc[(2*p+1)*ES +: ES] = mim;
      assign mp[(2*p)*ES +: ES]   = pre;
      assign mp[(2*p+1)*ES +: ES] = pim;
    end
  end

  logic [VW-1:0] wmask, mc_sel, mp_sel;
  logic [MW-1:0] lanes;

  assign wmask = q ? {VW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};

  always_comb begin
    case (sz)
      2'b01:   begin mc_sel = g_sz[0].mc; mp_sel = g_sz[0].mp; end
      2'b10:   begin mc_sel = g_sz[1].mc; mp_sel = g_sz[1].mp; end
      default: begin mc_sel = g_sz[2].mc; mp_sel = g_sz[2].mp; end
    endcase
  end

  always_comb begin
    lanes = '0;
    for (int i = 0; i < MW; i++)
      lanes[i] = (i * (16 << (sz - 2'd1))) < (q ? VW : HW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_mask   <= '0;
      out_addend <= '0;
      out_mcand  <= '0;
      out_mplier <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_undef  <= undef;
        out_mask   <= undef ? '0 : lanes;
        out_addend <= undef ? '0 : (acc & wmask);
        out_mcand  <= undef ? '0 : (mc_sel & wmask);
        out_mplier <= undef ? '0 : (mp_sel & wmask);
      end
    end
  end
endmodule

// File: rtl/cmla_steer_chk.sv
module cmla_steer_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   insn,
  input logic [VW-1:0] acc,
  input logic          out_valid,
  input logic          out_undef,
  input logic [VW/16-1:0] out_mask,
  input logic [VW-1:0] out_addend,
  input logic [VW-1:0] out_mcand,
  input logic [VW-1:0] out_mplier
);
  localparam int HW = VW / 2;

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(in_valid) |->
      $stable(out_mcand) && $stable(out_mplier) && $stable(out_addend) && $stable(out_mask));

  a_r3_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> out_mask == '0 && out_mcand == '0 && out_mplier == '0 && out_addend == '0);

  a_r11_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef |->
      out_mask[1:0] == 2'b11 && (out_mask & (out_mask + 1'b1)) == '0);

  a_r2_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) && $past(insn[23:22]) == 2'b00 |-> out_undef);

  a_r9_addend_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) && $past(insn[30]) && !out_undef |->
      out_addend == $past(acc));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) && !$past(insn[30]) |->
      out_mcand[VW-1:HW] == '0 && out_mplier[VW-1:HW] == '0 && out_addend[VW-1:HW] == '0);
endmodule

bind cmla_steer cmla_steer_chk #(.VW(VW)) u_chk (.*);

// File: tb/cmla_steer_bench.sv
module cmla_steer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic         half_en = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc = '0;
  logic         out_valid, out_undef;
  logic [7:0]   out_mask;
  logic [127:0] out_addend, out_mcand, out_mplier;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;

  logic         e_valid = 0, e_undef = 0;
  logic [7:0]   e_mask = '0;
  logic [127:0] e_ad = '0, e_mc = '0, e_mp = '0;
  string t_und = "R12", t_mask = "R12", t_ad = "R12", t_mc = "R12", t_mp = "R12";

  always #4 clk = ~clk;

  cmla_steer u_cmla_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .half_en(half_en),
    .src_a(src_a), .src_b(src_b), .acc(acc), .out_valid(out_valid), .out_undef(out_undef),
    .out_mask(out_mask), .out_addend(out_addend), .out_mcand(out_mcand), .out_mplier(out_mplier)
  );

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("R12", "out_valid", {127'd0, out_valid}, {127'd0, e_valid});
    check(t_und, "out_undef", {127'd0, out_undef}, {127'd0, e_undef});
    check(t_mask, "out_mask", {120'd0, out_mask}, {120'd0, e_mask});
    check(t_ad, "out_addend", out_addend, e_ad);
    check(t_mc, "out_mcand", out_mcand, e_mc);
    check(t_mp, "out_mplier", out_mplier, e_mp);
  endtask

  function automatic logic [31:0] mk(bit q, logic [1:0] sz, logic [1:0] rot);
    return {1'b0, q, 6'b101110, sz, 1'b0, 5'd3, 3'b110, rot, 1'b1, 10'h0a5};
  endfunction

  task automatic model(logic [31:0] w, bit h, logic [127:0] a, logic [127:0] b, logic [127:0] c);
    bit q = w[30];
    int sz = w[23:22];
    int rot = w[12:11];
    bit fixed_ok = w[31] == 0 && w[29:24] == 6'b101110 && w[21] == 0 &&
                   w[15:13] == 3'b110 && w[10] == 1;
    bit und = !fixed_ok || sz == 0 || (!q && sz == 3) || (sz == 1 && !h);
    string rt;
    e_undef = und;
    t_und = fixed_ok ? "R2" : "R1";
    e_mask = '0; e_ad = '0; e_mc = '0; e_mp = '0;
    if (und) begin
      t_mask = "R3"; t_ad = "R3"; t_mc = "R3"; t_mp = "R3";
      return;
    end
    case (rot)
      0: rt = "R4";
      1: rt = "R5";
      2: rt = "R6";
      default: rt = "R7";
    endcase
    t_mask = "R11"; t_ad = "R9"; t_mc = rt; t_mp = (rot == 0) ? rt : {rt, "/R8"};
    if (!q) begin
      t_ad = {t_ad, "/R10"}; t_mc = {t_mc, "/R10"}; t_mp = {t_mp, "/R10"};
    end
    begin
      int es = 8 << sz;
      int n = (q ? 128 : 64) / es;
      logic [127:0] em = {128{1'b1}} >> (128 - es);
      logic [127:0] sb = 128'd1 << (es - 1);
      e_ad = q ? c : {64'd0, c[63:0]};
      for (int i = 0; i < n; i++) e_mask[i] = 1'b1;
      for (int e = 0; e < n; e += 2) begin
        logic [127:0] ar = (a >> (e * es)) & em;
        logic [127:0] ai = (a >> ((e + 1) * es)) & em;
        logic [127:0] br = (b >> (e * es)) & em;
        logic [127:0] bi = (b >> ((e + 1) * es)) & em;
        logic [127:0] m0, m1, p0, p1;
        case (rot)
          0: begin m0 = ar; p0 = br;      m1 = ar; p1 = bi;      end
          1: begin m0 = ai; p0 = bi ^ sb; m1 = ai; p1 = br;      end
          2: begin m0 = ar; p0 = br ^ sb; m1 = ar; p1 = bi ^ sb; end
          default: begin m0 = ai; p0 = bi; m1 = ai; p1 = br ^ sb; end
        endcase
        e_mc |= (m0 << (e * es)) | (m1 << ((e + 1) * es));
        e_mp |= (p0 << (e * es)) | (p1 << ((e + 1) * es));
      end
    end
  endtask

  task automatic cyc(bit v, logic [31:0] w, bit h, logic [127:0] a, logic [127:0] b, logic [127:0] c);
    @(negedge clk);
    compare();
    in_valid = v; insn = w; half_en = h; src_a = a; src_b = b; acc = c;
    e_valid = v;
    if (v) model(w, h, a, b, c);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] va, vb, vc;
    va = 128'h0f0e0d0c0b0a09080706050403020100;
    vb = 128'h8f8e8d8c8b8a89888786858483828180;
    vc = 128'h123456789abcdef0fedcba9876543210;
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R4..R7 at 32-bit, 128-bit vector
    for (int r = 0; r < 4; r++) cyc(1, mk(1, 2'b10, 2'(r)), 1, va, vb, vc);
    // 16-bit with and without half support (R2, R11)
    cyc(1, mk(1, 2'b01, 2'b01), 1, va, vb, vc);
    cyc(1, mk(1, 2'b01, 2'b01), 0, va, vb, vc);
    cyc(1, mk(0, 2'b01, 2'b11), 1, va, vb, vc);
    // 64-bit elements
    cyc(1, mk(1, 2'b11, 2'b10), 0, va, vb, vc);
    cyc(1, mk(0, 2'b11, 2'b00), 1, va, vb, vc);
    cyc(1, mk(0, 2'b10, 2'b11), 1, va, vb, vc);
    cyc(1, mk(1, 2'b00, 2'b00), 1, va, vb, vc);
    // R1 fixed-bit violations
    cyc(1, mk(1, 2'b10, 2'b00) ^ 32'h8000_0000, 1, va, vb, vc);
    cyc(1, mk(1, 2'b10, 2'b00) ^ 32'h0000_0400, 1, va, vb, vc);
    cyc(1, mk(1, 2'b10, 2'b00) ^ 32'h0020_0000, 1, va, vb, vc);
    // R8 NaN payload negation
    cyc(1, mk(1, 2'b10, 2'b10), 1, va, {32'h7fc00001, 32'hffc00002, 32'h7f800001, 32'h7fc00001}, vc);
    cyc(1, mk(1, 2'b01, 2'b10), 1, va, {16'h7e01, 16'hfe02, 96'h0}, vc);
    // R12 hold while idle with changing inputs
    cyc(0, 32'hffff_ffff, 0, rnd128(), rnd128(), rnd128());
    cyc(0, mk(1, 2'b10, 2'b01), 1, rnd128(), rnd128(), rnd128());
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = mk($urandom_range(1), 2'($urandom_range(3)), 2'($urandom_range(3)));
      w[20:16] = 5'($urandom); w[9:0] = 10'($urandom);
      if ($urandom_range(9) == 0) w ^= 32'd1 << $urandom_range(31);
      cyc($urandom_range(3) != 0, w, $urandom_range(1), rnd128(), rnd128(), rnd128());
    end
    // R12 reset clears outputs
    @(negedge clk);
    compare();
    rst_n = 1'b0; in_valid = 1'b1;
    e_valid = 0; e_undef = 0; e_mask = '0; e_ad = '0; e_mc = '0; e_mp = '0;
    t_und = "R12"; t_mask = "R12"; t_ad = "R12"; t_mc = "R12"; t_mp = "R12";
    @(negedge clk);
    compare();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule